// File: doc/BRIEF.md
# Parallel-In Serial-Out FIFO with Occupancy Flags

This block buffers fixed-width words arriving on a parallel write port and sends them out one bit at a time on a single serial line. Each cycle in which the shift enable is high moves one bit onto the serial output. When a word has been fully shifted, the next stored word enters the shifter on the following shift cycle with no idle gap between them. A direction input, sampled at the moment each word enters the shifter, selects whether that word leaves least significant bit first or most significant bit first.

Four active-low flags report how many words are stored: empty, full, more-than-half-full, and an outer-band flag. The outer-band flag is low near either end of the range and high in the middle. The whole design runs in one clock domain. The memory depth is a parameter and must be a power of two that is at least 8 (for example 256, 512 or 1024). The word in the shifter no longer counts toward occupancy: it leaves the memory when it is loaded.

Top module: `pso_fifo`

## Requirements
- R1: While reset is active, and directly after it, emptyN and edgeN are 0, fullN and halfN are 1, and serOut is 0.
- R2: Words leave the serial output in the order they were accepted, every bit of each word appearing once, one bit per cycle with shiftEn high, and the next word following the last bit of the previous one with no gap when a stored word is available.
- R3: A word loaded while msbFirst is 0 is sent bit 0 first, then bit 1, and so on up to bit 15.
- R4: A word loaded while msbFirst is 1 is sent bit 15 first, then down to bit 0.
- R5: msbFirst is sampled only in the cycle a word enters the shifter; changing it in the middle of a word does not change that word's bit order.
- R6: A write while fullN is 0 is ignored: the word is not stored and the occupancy does not change.
- R7: With no bits left in the shifter and no stored word, shiftEn has no effect: no word loads and serOut keeps the last bit it drove.
- R8: emptyN is 0 exactly when 0 words are stored, and fullN is 0 exactly when DEPTH words are stored.
- R9: halfN is 0 when more than DEPTH/2 words are stored (129 or more for DEPTH 256) and 1 from 0 up to DEPTH/2 words.
- R10: edgeN is 0 for occupancy 0 to DEPTH/8-1 and from 7*DEPTH/8+1 to DEPTH, and 1 from DEPTH/8 to 7*DEPTH/8 (for DEPTH 256: 0 at 0-31, 1 at 32-224, 0 at 225-256).
- R11: An accepted write in the same cycle as a word load leaves the occupancy and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the write port and the shifter |
| rst_n | input | 1 | Synchronous reset, active low |
| wrStrobe | input | 1 | Write request for wrData in this cycle |
| wrData | input | 16 | Word to store |
| shiftEn | input | 1 | Move one bit onto serOut in this cycle |
| msbFirst | input | 1 | Bit order for the next word loaded: 0 low bit first, 1 high bit first |
| serOut | output | 1 | Serial data bit |
| emptyN | output | 1 | Low when no word is stored |
| fullN | output | 1 | Low when DEPTH words are stored |
| halfN | output | 1 | Low when more than half the depth is stored |
| edgeN | output | 1 | Low below one eighth or above seven eighths of the depth |

## Verification
Every result is due one rising edge after the inputs that cause it. A write or a load shows on the flags after that edge. A bit moved by shiftEn appears on serOut after the same edge that samples shiftEn. The bench applies its inputs at falling edges. After each rising edge it advances a behavioural queue model, and at the next falling edge it compares all five outputs with the model. Bit order, ignored writes and flag thresholds are therefore checked in exactly the cycle they take effect.

// File: rtl/pso_pkg.sv
package pso_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;   // store wrData at the write pointer
    logic load;   // move the oldest word into the shifter
    logic shift;  // emit the next bit of the word in the shifter
  } pso_strobe_t;
endpackage

// File: rtl/pso_ctl.sv
module pso_ctl
  import pso_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrStrobe,
  input  logic        shiftEn,
  output pso_strobe_t strobe,
  output logic        emptyN,
  output logic        fullN,
  output logic        halfN,
  output logic        edgeN
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LOW_C  = CW'(DEPTH / 8);
  localparam logic [CW-1:0] HIGH_C = CW'((DEPTH * 7) / 8);
  localparam logic [BW-1:0] LAST_C = BW'(WORD_W - 1);

  logic [CW-1:0] wordCount;
  logic [BW-1:0] bitsLeft;

  always_comb begin
    strobe.push  = wrStrobe && (wordCount != FULL_C);
    strobe.load  = shiftEn && (bitsLeft == '0) && (wordCount != '0);
    strobe.shift = shiftEn && (bitsLeft != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordCount <= '0;
      bitsLeft  <= '0;
    end else begin
      if (strobe.push && !strobe.load)
        wordCount <= wordCount + CW'(1);
      else if (strobe.load && !strobe.push)
        wordCount <= wordCount - CW'(1);
      if (strobe.load)
        bitsLeft <= LAST_C;
      else if (strobe.shift)
        bitsLeft <= bitsLeft - BW'(1);
    end
  end

  always_comb begin
    emptyN = (wordCount != '0);
    fullN  = (wordCount != FULL_C);
    halfN  = (wordCount <= HALF_C);
    edgeN  = (wordCount >= LOW_C) && (wordCount <= HIGH_C);
  end
endmodule

// File: rtl/pso_dp.sv
module pso_dp
  import pso_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pso_strobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic              msbFirst,
  output logic              serOut
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] store [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [WORD_W-1:0] shreg;
  logic              highFirst;
  logic              serReg;
  logic [WORD_W-1:0] headWord;

  assign headWord = store[rdPtr];
  assign serOut   = serReg;

  always_ff @(posedge clk) begin
    if (strobe.push)
      store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      shreg     <= '0;
      highFirst <= 1'b0;
      serReg    <= 1'b0;
    end else begin
      if (strobe.push)
        wrPtr <= wrPtr + AW'(1);
      if (strobe.load) begin
        rdPtr     <= rdPtr + AW'(1);
        highFirst <= msbFirst;
        if (msbFirst) begin
          serReg <= headWord[WORD_W-1];
          shreg  <= headWord << 1;
        end else begin
          serReg <= headWord[0];
          shreg  <= headWord >> 1;
        end
      end else if (strobe.shift) begin
        if (highFirst) begin
          serReg <= shreg[WORD_W-1];
          shreg  <= shreg << 1;
        end else begin
          serReg <= shreg[0];
          shreg  <= shreg >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/pso_fifo.sv
module pso_fifo #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic              shiftEn,
  input  logic              msbFirst,
  output logic              serOut,
  output logic              emptyN,
  output logic              fullN,
  output logic              halfN,
  output logic              edgeN
);
  pso_pkg::pso_strobe_t strobe;

  pso_ctl #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrStrobe (wrStrobe),
    .shiftEn  (shiftEn),
    .strobe   (strobe),
    .emptyN   (emptyN),
    .fullN    (fullN),
    .halfN    (halfN),
    .edgeN    (edgeN)
  );

  pso_dp #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wrData   (wrData),
    .msbFirst (msbFirst),
    .serOut   (serOut)
  );
endmodule

// File: rtl/pso_fifo_chk.sv
module pso_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic wrStrobe,
  input logic shiftEn,
  input logic serOut,
  input logic emptyN,
  input logic fullN,
  input logic halfN,
  input logic edgeN
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!fullN && wrStrobe && !shiftEn) |=> !fullN); // R6

  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!emptyN && !fullN)); // R8

  AST_EMPTY_LEAVES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emptyN) |-> $past(wrStrobe)); // R8

  AST_SER_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shiftEn |=> $stable(serOut)); // R7

  AST_FULL_ABOVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !fullN |-> !halfN); // R9

  AST_EDGE_AT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fullN || !emptyN) |-> !edgeN); // R10
endmodule

bind pso_fifo pso_fifo_chk u_chk (.*);

// File: tb/pso_fifo_test.sv
`timescale 1ns/1ps
module pso_fifo_test;
  localparam int DEPTH = 256;
  localparam int W     = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wrStrobe = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         shiftEn = 1'b0;
  logic         msbFirst = 1'b0;
  logic         serOut, emptyN, fullN, halfN, edgeN;

  int checks = 0;
  int errors = 0;
  string phaseTag = "R2";

  logic [W-1:0] wordQ[$];
  bit           bitQ[$];
  bit           expSer = 1'b0;

  always #2 clk = ~clk;

  pso_fifo #(.DEPTH(DEPTH), .WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrData(wrData),
    .shiftEn(shiftEn), .msbFirst(msbFirst), .serOut(serOut),
    .emptyN(emptyN), .fullN(fullN), .halfN(halfN), .edgeN(edgeN)
  );

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b (t=%0t)", tag, nm, act, exp, $time);
    end
  endtask

  // reference: queue of stored words plus queue of pending bits
  task automatic model_step();
    int  n;
    bit  wasFull;
    bit  canPop;
    n       = wordQ.size();
    wasFull = (n == DEPTH);
    canPop  = (n != 0) && (bitQ.size() == 0);
    if (shiftEn) begin
      if (bitQ.size() != 0) begin
        expSer = bitQ.pop_front();
      end else if (canPop) begin
        logic [W-1:0] w;
        w = wordQ.pop_front();
        for (int i = 0; i < W; i++)
          bitQ.push_back(msbFirst ? w[W-1-i] : w[i]);
        expSer = bitQ.pop_front();
      end
    end
    if (wrStrobe && !wasFull) wordQ.push_back(wrData);
  endtask

  task automatic tick();
    int n;
    @(posedge clk);
    model_step();
    @(negedge clk);
    n = wordQ.size();
    chk(phaseTag, "serOut", serOut, expSer);
    chk("R8", "emptyN", emptyN, n != 0);
    chk("R8", "fullN", fullN, n != DEPTH);
    chk("R9", "halfN", halfN, n <= DEPTH / 2);
    chk("R10", "edgeN", edgeN, (n >= DEPTH / 8) && (n <= (7 * DEPTH) / 8));
  endtask

  task automatic put(logic [W-1:0] d);
    wrStrobe = 1'b1; wrData = d;
    tick();
    wrStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "emptyN", emptyN, 1'b0);
    chk("R1", "fullN", fullN, 1'b1);
    chk("R1", "halfN", halfN, 1'b1);
    chk("R1", "edgeN", edgeN, 1'b0);
    chk("R1", "serOut", serOut, 1'b0);
    rst_n = 1'b1;

    // R3: low bit first
    phaseTag = "R3";
    msbFirst = 1'b0;
    put(16'h8001); put(16'h00F6); put(16'hA5C3);
    shiftEn = 1'b1;
    repeat (3 * W) tick();
    // R7: shifting with nothing left holds the last bit
    phaseTag = "R7";
    repeat (6) tick();
    shiftEn = 1'b0;
    tick();

    // R4: high bit first
    phaseTag = "R4";
    msbFirst = 1'b1;
    put(16'h8001); put(16'h3C5A); put(16'hFFFE);
    shiftEn = 1'b1;
    repeat (3 * W + 2) tick();
    shiftEn = 1'b0;

    // R5: direction change mid-word only affects the next word
    phaseTag = "R5";
    msbFirst = 1'b0;
    put(16'h0F31); put(16'h0F31);
    shiftEn = 1'b1;
    repeat (5) tick();
    msbFirst = 1'b1;
    repeat (2 * W) tick();
    shiftEn = 1'b0;
    tick();

    // R6/R9/R10: fill past the depth without shifting
    phaseTag = "R6";
    for (int i = 0; i < DEPTH + 3; i++) put(16'(i * 16'h0123 + 7));
    // R11: writes during loads keep the count; then drain
    phaseTag = "R11";
    shiftEn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      wrStrobe = (i % W) == 0;
      wrData   = 16'(16'hC0DE ^ i);
      tick();
    end
    wrStrobe = 1'b0;
    phaseTag = "R2";
    repeat ((DEPTH + 4) * W) tick();
    shiftEn = 1'b0;
    tick();

    // mixed traffic
    phaseTag = "R11";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wrStrobe = lfsr[0] & lfsr[7];
      shiftEn  = lfsr[3] | lfsr[5];
      msbFirst = lfsr[9];
      wrData   = lfsr ^ 16'(i);
      tick();
    end
    wrStrobe = 1'b0;
    shiftEn  = 1'b0;
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule